// File: doc/BRIEF.md
# Indexed Register-File Gather Move

This block is a sequencer that carries out an indirect move inside a 32-entry register file. Once `start_i` is accepted it walks through `VL * SUBVL` elements, one per clock. For element `k` it writes register `rd + k`. Normal and sub-vector gathers read an index from the index register `rs1` and copy the register at the destination base plus that index. Swizzle reads a 2-bit selector field from `rs2` and copies from a window based at `rs1`. The register file itself lives outside the block and is reached through two combinational read ports and one write port.

Indices may be packed as bytes, as half-words, or as full 32-bit words, so one register can carry up to four indices. The packing is independent of the width of the data being moved. A sub-vector mode restarts the index position at every sub-vector, which supports transposition-style shuffles. Every element sees the writes of the elements before it. An out-of-range address stops the operation and sets an error flag that comes with the done pulse.

Top module: `gm_gather_move`

## Requirements
- R1: After reset `busy_o`, `done_o`, `err_o` and `we_o` are all low, and they stay low until a start is accepted.
- R2: With `fn4_i[1:0]` = 01 (normal gather), element k (k = 0 .. VL*SUBVL-1) writes register `rd+k` with the value of register `rd+idx(k)`. One element completes on each clock.
- R3: `fn4_i[3:2]` selects the index packing. Value 1 takes byte `p%4` of register `rs1+p/4`, with byte 0 in bits 7:0. Value 2 takes half-word `p%2` of register `rs1+p/2`, with half 0 in bits 15:0. Values 0 and 3 take the whole register `rs1+p`. Here p is the index position.
- R4: With `fn4_i[1:0]` = 11 (sub-vector gather) and S = `subvl_i`+1, element k = v*S+j writes `rd+k` from register `rd+v*S+idx(j)`. The index position is j, so it restarts at every sub-vector.
- R5: With `fn4_i` = 0000 (swizzle), element k = v*S+j writes `rd+k` from register `rs1+v*S+f`. Here f is bits 2j+1:2j of register `rs2`.
- R6: `done_o` is a one-cycle pulse. It rises on the N-th clock edge after the edge that accepted start, where N = VL*SUBVL. With VL = 0 it rises on the accepting edge and nothing is written.
- R7: If the index register address, the index value, the source address or the destination address reaches 32 or more, that element is not written. The operation stops and `done_o` rises on the next edge with `err_o` high.
- R8: Register 0 reads as zero on both read ports. A write aimed at register 0 is suppressed, but the element still takes its cycle.
- R9: A reserved `fn4_i` (low bits 00 with a nonzero value, or low bits 10) produces `done_o` with `err_o` on the accepting edge and writes nothing.
- R10: `start_i` and the field inputs are ignored while `busy_o` is high.
- R11: An element reads values already written by earlier elements of the same operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled while idle |
| rd_i | input | 5 | Destination base register |
| rs1_i | input | 5 | Index register (gather) or source base (swizzle) |
| rs2_i | input | 5 | Selector register for swizzle |
| fn4_i | input | 4 | Function code: [1:0] operation, [3:2] index packing |
| vl_i | input | 6 | Vector length |
| subvl_i | input | 2 | Sub-vector length minus one |
| busy_o | output | 1 | Operation in progress, done cycle included |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Error flag, valid with done_o |
| ra_addr_o | output | 5 | Read port A address (index or selector register) |
| ra_data_i | input | 32 | Read port A data |
| rb_addr_o | output | 5 | Read port B address (source register) |
| rb_data_i | input | 32 | Read port B data |
| we_o | output | 1 | Register write enable |
| wa_o | output | 5 | Register write address |
| wd_o | output | 32 | Register write data |

## Verification
A wrong element counter or sub-vector counter appears on the write port in the same cycle as a wrong address. It also moves the edge on which `done_o` rises, so the bench compares done timing to the edge and the final register file word by word. A field-extraction fault or a base-selection fault corrupts the written value in the element where it occurs. Because later elements read earlier results, that fault spreads through the rest of the operation. An error-detection fault shows either as a write beyond the register file, which wraps into low registers, or as an early `err_o` with the tail of the operation left unwritten.

// File: rtl/gm_pkg.sv
package gm_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} gm_state_e;
  typedef enum logic [1:0] {OP_SWZ, OP_NORM, OP_SUBV, OP_BAD} gm_op_e;
  typedef enum logic [1:0] {IW_FULL = 2'd0, IW_8 = 2'd1, IW_16 = 2'd2, IW_32 = 2'd3} gm_iw_e;

  function automatic gm_op_e decode_fn(input logic [3:0] fn);
    if (fn == 4'b0000)       return OP_SWZ;
    else if (fn[1:0] == 2'b01) return OP_NORM;
    else if (fn[1:0] == 2'b11) return OP_SUBV;
    else                     return OP_BAD;
  endfunction
endpackage

// File: rtl/gm_seq.sv
module gm_seq
  import gm_pkg::*;
#(
  parameter int AW  = 5,
  parameter int VLW = 6,
  parameter int SVW = 2,
  localparam int CW = VLW + SVW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [AW-1:0]     rd_i,
  input  logic [AW-1:0]     rs1_i,
  input  logic [AW-1:0]     rs2_i,
  input  logic [3:0]        fn4_i,
  input  logic [VLW-1:0]    vl_i,
  input  logic [SVW-1:0]    subvl_i,
  input  logic              elem_bad_i,
  output gm_state_e         state_o,
  output gm_op_e            op_o,
  output logic [1:0]        iw_o,
  output logic [AW-1:0]     rd_o,
  output logic [AW-1:0]     rs1_o,
  output logic [AW-1:0]     rs2_o,
  output logic [CW-1:0]     k_o,
  output logic [CW-1:0]     j_o,
  output logic [CW-1:0]     vbase_o,
  output logic              err_o
);
  gm_state_e      state_q;
  gm_op_e         op_q;
  logic [1:0]     iw_q;
  logic [AW-1:0]  rd_q, rs1_q, rs2_q;
  logic [CW-1:0]  k_q, j_q, vb_q, s_q, n_q;
  logic           err_q;

  logic [CW-1:0]  s_w, n_w;
  gm_op_e         op_w;
  logic           last_k, last_j;

  assign s_w    = CW'(subvl_i) + CW'(1);
  assign n_w    = CW'(vl_i) * s_w;
  assign op_w   = decode_fn(fn4_i);
  assign last_k = (k_q == n_q - CW'(1));
  assign last_j = (j_q == s_q - CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      op_q    <= OP_BAD;
      iw_q    <= '0;
      rd_q    <= '0;
      rs1_q   <= '0;
      rs2_q   <= '0;
      k_q     <= '0;
      j_q     <= '0;
      vb_q    <= '0;
      s_q     <= CW'(1);
      n_q     <= '0;
      err_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          op_q  <= op_w;
          iw_q  <= fn4_i[3:2];
          rd_q  <= rd_i;
          rs1_q <= rs1_i;
          rs2_q <= rs2_i;
          s_q   <= s_w;
          n_q   <= n_w;
          k_q   <= '0;
          j_q   <= '0;
          vb_q  <= '0;
          if (op_w == OP_BAD) begin
            err_q   <= 1'b1;
            state_q <= ST_DONE;
          end else begin
            err_q   <= 1'b0;
            state_q <= (vl_i == '0) ? ST_DONE : ST_RUN;
          end
        end
        ST_RUN: begin
          if (elem_bad_i) begin
            err_q   <= 1'b1;
            state_q <= ST_DONE;
          end else if (last_k) begin
            state_q <= ST_DONE;
          end else begin
            k_q <= k_q + CW'(1);
            if (last_j) begin
              j_q  <= '0;
              vb_q <= vb_q + s_q;
            end else begin
              j_q <= j_q + CW'(1);
            end
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
  assign op_o    = op_q;
  assign iw_o    = iw_q;
  assign rd_o    = rd_q;
  assign rs1_o   = rs1_q;
  assign rs2_o   = rs2_q;
  assign k_o     = k_q;
  assign j_o     = j_q;
  assign vbase_o = vb_q;
  assign err_o   = (state_q == ST_DONE) && err_q;

  p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DONE) |=> (state_q != ST_DONE));

  p_fields_stable_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN) |=> $stable({rd_q, rs1_q, rs2_q, op_q, iw_q, n_q, s_q}));

  p_k_advance_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && $past(state_q) == ST_RUN) |-> (k_q == $past(k_q) + CW'(1)));
endmodule

// File: rtl/gm_idx.sv
module gm_idx
  import gm_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int CW   = 8,
  localparam int N8  = XLEN / 8,
  localparam int N16 = XLEN / 16,
  localparam int B8  = $clog2(N8),
  localparam int B16 = $clog2(N16)
) (
  input  logic [XLEN-1:0] word_i,
  input  logic [CW-1:0]   pos_i,
  input  logic [1:0]      iw_i,
  output logic [CW-1:0]   woff_o,
  output logic [XLEN-1:0] idx_o
);
  logic [7:0]  lane8  [N8];
  logic [15:0] lane16 [N16];

  for (genvar g = 0; g < N8; g++) begin : g_l8
    assign lane8[g] = word_i[8*g +: 8];
  end
  for (genvar g = 0; g < N16; g++) begin : g_l16
    assign lane16[g] = word_i[16*g +: 16];
  end

  always_comb begin
    case (iw_i)
      IW_8: begin
        woff_o = pos_i >> B8;
        idx_o  = XLEN'(lane8[pos_i[B8-1:0]]);
      end
      IW_16: begin
        woff_o = pos_i >> B16;
        idx_o  = XLEN'(lane16[pos_i[B16-1:0]]);
      end
      default: begin  // full word; equals 32-bit packing at XLEN=32
        woff_o = pos_i;
        idx_o  = word_i;
      end
    endcase
  end
endmodule

// File: rtl/gm_addr.sv
module gm_addr
  import gm_pkg::*;
#(
  parameter int AW   = 5,
  parameter int XLEN = 32,
  parameter int CW   = 8,
  localparam int SW  = CW + 2,
  localparam int NREG = 1 << AW
) (
  input  gm_op_e          op_i,
  input  logic [AW-1:0]   rd_i,
  input  logic [AW-1:0]   rs1_i,
  input  logic [AW-1:0]   rs2_i,
  input  logic [CW-1:0]   k_i,
  input  logic [1:0]      j_i,
  input  logic [CW-1:0]   vbase_i,
  input  logic [CW-1:0]   woff_i,
  input  logic [XLEN-1:0] idx_i,
  input  logic [XLEN-1:0] ra_word_i,
  output logic [AW-1:0]   ra_addr_o,
  output logic [AW-1:0]   src_o,
  output logic [AW-1:0]   dest_o,
  output logic            bad_o
);
  logic [SW-1:0] ra_full, base, off, src_full, dest_full;
  logic [1:0]    sel_f;
  logic          swz, ra_bad, idx_bad;

  assign swz       = (op_i == OP_SWZ);
  assign ra_full   = swz ? SW'(rs2_i) : SW'(rs1_i) + SW'(woff_i);
  assign ra_bad    = ra_full >= SW'(NREG);
  assign sel_f     = ra_word_i[{j_i, 1'b0} +: 2];
  assign idx_bad   = !swz && (idx_i >= XLEN'(NREG));
  assign off       = swz ? SW'(sel_f) : SW'(idx_i[AW-1:0]);

  always_comb begin
    case (op_i)
      OP_SWZ:  base = SW'(rs1_i) + SW'(vbase_i);
      OP_SUBV: base = SW'(rd_i) + SW'(vbase_i);
      default: base = SW'(rd_i);
    endcase
  end

  assign src_full  = base + off;
  assign dest_full = SW'(rd_i) + SW'(k_i);
  assign bad_o     = ra_bad || idx_bad || (src_full >= SW'(NREG)) || (dest_full >= SW'(NREG));
  assign ra_addr_o = ra_full[AW-1:0];
  assign src_o     = src_full[AW-1:0];
  assign dest_o    = dest_full[AW-1:0];
endmodule

// File: rtl/gm_gather_move.sv
module gm_gather_move
  import gm_pkg::*;
#(
  parameter int NREG = 32,
  parameter int XLEN = 32,
  parameter int VLW  = 6,
  localparam int AW  = $clog2(NREG),
  localparam int SVW = 2,
  localparam int CW  = VLW + SVW
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [AW-1:0]   rd_i,
  input  logic [AW-1:0]   rs1_i,
  input  logic [AW-1:0]   rs2_i,
  input  logic [3:0]      fn4_i,
  input  logic [VLW-1:0]  vl_i,
  input  logic [SVW-1:0]  subvl_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            err_o,
  output logic [AW-1:0]   ra_addr_o,
  input  logic [XLEN-1:0] ra_data_i,
  output logic [AW-1:0]   rb_addr_o,
  input  logic [XLEN-1:0] rb_data_i,
  output logic            we_o,
  output logic [AW-1:0]   wa_o,
  output logic [XLEN-1:0] wd_o
);
  gm_state_e     state;
  gm_op_e        op;
  logic [1:0]    iw;
  logic [AW-1:0] rd_q, rs1_q, rs2_q, src, dest;
  logic [CW-1:0] k, j, vbase, pos, woff;
  logic [XLEN-1:0] ra_w, rb_w, idx;
  logic          bad, run;

  gm_seq #(.AW(AW), .VLW(VLW), .SVW(SVW)) u_seq (
    .clk_i, .rst_ni, .start_i,
    .rd_i, .rs1_i, .rs2_i, .fn4_i, .vl_i, .subvl_i,
    .elem_bad_i (bad),
    .state_o (state), .op_o (op), .iw_o (iw),
    .rd_o (rd_q), .rs1_o (rs1_q), .rs2_o (rs2_q),
    .k_o (k), .j_o (j), .vbase_o (vbase),
    .err_o (err_o)
  );

  // register 0 is hard-wired to zero on both read ports
  assign ra_w = (ra_addr_o == '0) ? '0 : ra_data_i;
  assign rb_w = (rb_addr_o == '0) ? '0 : rb_data_i;
  assign pos  = (op == OP_SUBV) ? j : k;

  gm_idx #(.XLEN(XLEN), .CW(CW)) u_idx (
    .word_i (ra_w), .pos_i (pos), .iw_i (iw),
    .woff_o (woff), .idx_o (idx)
  );

  gm_addr #(.AW(AW), .XLEN(XLEN), .CW(CW)) u_addr (
    .op_i (op), .rd_i (rd_q), .rs1_i (rs1_q), .rs2_i (rs2_q),
    .k_i (k), .j_i (j[1:0]), .vbase_i (vbase), .woff_i (woff),
    .idx_i (idx), .ra_word_i (ra_w),
    .ra_addr_o (ra_addr_o), .src_o (src), .dest_o (dest), .bad_o (bad)
  );

  assign run       = (state == ST_RUN);
  assign rb_addr_o = src;
  assign we_o      = run && !bad && (dest != '0);
  assign wa_o      = dest;
  assign wd_o      = rb_w;
  assign busy_o    = (state != ST_IDLE);
  assign done_o    = (state == ST_DONE);

  p_we_in_run_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |-> (busy_o && !done_o));

  p_wa_ascending_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_o && $past(we_o)) |-> (wa_o == $past(wa_o) + AW'(1)));

  p_err_ends_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !busy_o);
endmodule

// File: tb/sim_gm_gather_move.sv
`timescale 1ns/1ps
module sim_gm_gather_move;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        start_i = 1'b0;
  logic [4:0]  rd_i = '0, rs1_i = '0, rs2_i = '0;
  logic [3:0]  fn4_i = '0;
  logic [5:0]  vl_i = '0;
  logic [1:0]  subvl_i = '0;
  logic        busy_o, done_o, err_o, we_o;
  logic [4:0]  ra_addr_o, rb_addr_o, wa_o;
  logic [31:0] ra_data_i, rb_data_i, wd_o;

  logic [31:0] mem    [32];
  logic [31:0] init_m [32];
  logic [31:0] exp_m  [32];
  logic        ld = 1'b0;

  int n_chk = 0, n_fail = 0, cyc = 0;

  gm_gather_move u0 (
    .clk_i (clk), .rst_ni (rst_n), .start_i,
    .rd_i, .rs1_i, .rs2_i, .fn4_i, .vl_i, .subvl_i,
    .busy_o, .done_o, .err_o,
    .ra_addr_o, .ra_data_i, .rb_addr_o, .rb_data_i,
    .we_o, .wa_o, .wd_o
  );

  always_ff @(posedge clk) begin
    if (ld) mem <= init_m;
    else if (we_o) mem[wa_o] <= wd_o;
  end
  assign ra_data_i = mem[ra_addr_o];
  assign rb_data_i = mem[rb_addr_o];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  function automatic logic [31:0] rdreg(input int a);
    return (a == 0) ? 32'd0 : exp_m[a];
  endfunction

  // reference model: updates exp_m sequentially, returns done edge and error
  task automatic ref_op(input int rd, rs1, rs2, fn, vl, sv,
                        output int edges, output bit err);
    int s = sv + 1;
    int n = vl * s;
    edges = n; err = 0;
    if (!(fn == 0 || (fn & 3) == 1 || (fn & 3) == 3)) begin
      edges = 0; err = 1; return;
    end
    for (int k = 0; k < n; k++) begin
      int v = k / s;
      int j = k % s;
      int src, dst;
      bit bad = 0;
      if (fn == 0) begin
        logic [31:0] sel = rdreg(rs2);
        src = rs1 + v * s + int'((sel >> (2 * j)) & 32'd3);
      end else begin
        bit sub = ((fn & 3) == 3);
        int p = sub ? j : k;
        int w = (fn >> 2) & 3;
        int bits = (w == 1) ? 8 : (w == 2) ? 16 : 32;
        int per = 32 / bits;
        int ir = rs1 + p / per;
        logic [31:0] word, id;
        if (ir >= 32) bad = 1;
        word = (ir >= 32) ? 32'd0 : rdreg(ir);
        id = (bits == 32) ? word : ((word >> (bits * (p % per))) & ((32'd1 << bits) - 32'd1));
        if (id >= 32) bad = 1;
        src = (sub ? rd + v * s : rd) + int'(id[5:0]);
      end
      dst = rd + k;
      if (src >= 32 || dst >= 32) bad = 1;
      if (bad) begin
        edges = k + 1; err = 1; return;
      end
      if (dst != 0) exp_m[dst] = rdreg(src);
    end
  endtask

  task automatic fill_regs();
    for (int i = 0; i < 32; i++) begin
      case ($urandom % 3)
        0: init_m[i] = $urandom % 24;
        1: init_m[i] = {8'($urandom % 20), 8'($urandom % 20), 8'($urandom % 20), 8'($urandom % 20)};
        default: init_m[i] = {16'($urandom % 20), 16'($urandom % 20)};
      endcase
    end
    init_m[0] = 32'hDEAD_BEEF;
  endtask

  task automatic run_op(input string tag, input int rd, rs1, rs2, fn, vl, sv, input bit poke);
    int edges, c, mism, first;
    bit err;
    @(negedge clk); ld = 1'b1;
    @(negedge clk); ld = 1'b0;
    exp_m = init_m;
    ref_op(rd, rs1, rs2, fn, vl, sv, edges, err);
    rd_i = 5'(rd); rs1_i = 5'(rs1); rs2_i = 5'(rs2);
    fn4_i = 4'(fn); vl_i = 6'(vl); subvl_i = 2'(sv);
    start_i = 1'b1;
    c = 0;
    forever begin
      @(negedge clk);
      start_i = 1'b0;
      if (poke && c == 1) begin
        // spurious start with other fields while busy (R10)
        start_i = 1'b1; fn4_i = 4'b0100; rd_i = 5'd1; vl_i = 6'd1;
      end
      if (done_o) break;
      c++;
      if (c > 1000) break;
    end
    start_i = 1'b0;
    chk(c == edges, tag, "done edge", c, edges);
    chk(err_o == err, tag, "err flag", err_o, err);
    mism = 0; first = -1;
    for (int i = 0; i < 32; i++)
      if (mem[i] !== exp_m[i]) begin
        mism++;
        if (first < 0) first = i;
      end
    if (first >= 0)
      $display("  %s reg %0d: actual %h expected %h", tag, first, mem[first], exp_m[first]);
    chk(mism == 0, tag, "register mismatches", mism, 0);
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5EED);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busy_o && !done_o && !err_o && !we_o, "R1", "outputs under reset",
        {busy_o, done_o, err_o, we_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy_o && !done_o && !err_o && !we_o, "R1", "outputs idle after reset",
        {busy_o, done_o, err_o, we_o}, 0);

    // R2: normal gather, full-word indices
    fill_regs();
    init_m[4] = 3; init_m[5] = 0; init_m[6] = 2; init_m[7] = 1;
    run_op("R2", 10, 4, 0, 4'b1101, 4, 0, 0);

    // R3: byte, half-word and default packing
    fill_regs();
    init_m[2] = 32'h0200_0301;
    run_op("R3 byte", 20, 2, 0, 4'b0101, 4, 0, 0);
    fill_regs();
    init_m[2] = 32'h0005_0002; init_m[3] = 32'h0001_0000;
    run_op("R3 half", 16, 2, 0, 4'b1001, 4, 0, 0);
    fill_regs();
    init_m[4] = 5; init_m[5] = 1; init_m[6] = 0;
    run_op("R3 default", 12, 4, 0, 4'b0001, 3, 0, 0);

    // R4: sub-vector gather restarts index position
    fill_regs();
    init_m[1] = 32'h0001_0203;
    run_op("R4", 16, 1, 0, 4'b0111, 3, 3, 0);

    // R5: swizzle
    fill_regs();
    init_m[3] = 32'h0000_0072;
    run_op("R5", 20, 8, 3, 4'b0000, 2, 3, 0);

    // R6: zero length
    fill_regs();
    run_op("R6 vl0", 10, 4, 0, 4'b0101, 0, 2, 0);

    // R7: destination and index out of range
    fill_regs();
    for (int i = 4; i < 10; i++) init_m[i] = 1;
    run_op("R7 dest", 28, 4, 0, 4'b1101, 6, 0, 0);
    fill_regs();
    init_m[4] = 2; init_m[5] = 40;
    run_op("R7 index", 8, 4, 0, 4'b1101, 3, 0, 0);

    // R8: register 0 reads zero, writes to it suppressed
    fill_regs();
    init_m[4] = 0; init_m[5] = 0; init_m[6] = 0;
    run_op("R8", 0, 4, 0, 4'b1101, 3, 0, 0);

    // R9: reserved function codes
    fill_regs();
    run_op("R9 0110", 10, 4, 0, 4'b0110, 4, 0, 0);
    run_op("R9 0100", 10, 4, 0, 4'b0100, 4, 0, 0);

    // R10: start while busy ignored
    fill_regs();
    for (int i = 4; i < 12; i++) init_m[i] = i - 4;
    run_op("R10", 14, 4, 0, 4'b1101, 8, 0, 1);

    // R11: later elements see earlier writes
    fill_regs();
    init_m[4] = 1; init_m[5] = 0; init_m[6] = 1;
    run_op("R11", 10, 4, 0, 4'b1101, 3, 0, 0);

    // R2 random mix across all modes
    for (int t = 0; t < 300; t++) begin
      int fn, pick;
      fill_regs();
      pick = $urandom % 10;
      case (pick)
        0: fn = 0;
        1: fn = 4'b0110;
        default: fn = (($urandom % 4) << 2) | (($urandom % 2) ? 3 : 1);
      endcase
      run_op("R2 random", $urandom % 32, $urandom % 32, $urandom % 32, fn,
             $urandom % 10, $urandom % 4, 0);
    end

    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule